// File: doc/BRIEF.md
# Burst-Splitting AXI Read Master

This block turns one read request into a series of AXI read bursts. A request gives a start byte address, a byte count, a transfer size, a protection value, an ID, and an expected response code with an enable for that comparison. The start address need not be aligned. The block issues incrementing bursts on the read-address channel, one at a time. Each burst is kept inside a 4 KB page and inside a configurable beat limit. Each burst also stops at the last byte the request asked for.

As beats return on the read-data channel, the block keeps only the byte lanes that belong to the request. It then sends those bytes out one per cycle, in ascending address order, on a valid/ready byte stream. The stream marks the final byte of the whole request. Every beat's response code is compared with the expected code, and any mismatch raises a one-cycle flag.

Requests that are malformed produce a one-cycle error pulse instead of bus traffic. A request is malformed if it has no bytes, asks for a transfer wider than the data bus, or runs past the top of the address space.

Top module: `axrd_master`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` stays low until that request's last byte has been accepted on the output stream.
- R2: Each burst's `ar_addr` is the current byte address rounded down to a multiple of 2^`ar_size`. `ar_burst` is 2'b01 (incrementing). `ar_size`, `ar_prot` and `ar_id` repeat the request's values. While `ar_valid` is high and `ar_ready` is low, the burst fields do not change.
- R3: A burst ends at the earliest of three bytes: the request's final byte, the byte MAX_BEATS·2^size past the aligned address minus one, and the last byte of the current 2^PAGE_W-byte page. `ar_len` is the resulting beat count minus one, so it never exceeds MAX_BEATS−1 and a burst never crosses a page.
- R4: In a returned beat, the byte for address A sits in lane (A mod 2^size), where lane k is `r_data[8k+7:8k]`. For each beat the block keeps `count` lanes starting at lane `offset`. Here `offset` is the current address mod 2^size and `count` is min(bytes remaining, 2^size − `offset`). The current address then advances by `count`. Kept bytes appear on `out_byte` one per cycle, in ascending address order.
- R5: `out_last` is high with the final byte of the whole request and with no other byte, including the final bytes of earlier bursts.
- R6: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` hold their values and `r_ready` is low. No returned byte is lost or repeated under any backpressure pattern.
- R7: Response codes are OKAY=0, EXOKAY=1, SLVERR=2 and DECERR=3. When `req_check` is 1 and a beat's `r_resp` differs from `req_expect`, `resp_err` is high for exactly one cycle. That cycle is the first cycle in which the beat's first kept byte is offered on the output.
- R8: When `req_check` is 0, `resp_err` stays low whatever response codes return.
- R9: A request is rejected if `req_bytes` is 0, if `req_size` exceeds log2 of the bus width in bytes, or if `req_addr` + `req_bytes` exceeds 2^ADDR_W. On rejection, `req_err` pulses for one cycle in the cycle after acceptance, no burst is issued, and the block stays ready. A request that ends exactly at the top of the address space is accepted.
- R10: After reset, `req_ready` is 1 and `ar_valid`, `r_ready`, `out_valid`, `req_err` and `resp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | First byte address |
| req_bytes | input | CNT_W | Number of bytes to read |
| req_size | input | 3 | Transfer size, log2 of bytes per beat |
| req_prot | input | 3 | Protection value copied to every burst |
| req_id | input | ID_W | ID copied to every burst |
| req_check | input | 1 | 1 enables the response comparison |
| req_expect | input | 2 | Expected response code |
| req_err | output | 1 | One-cycle pulse: request rejected |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Size-aligned burst address |
| ar_len | output | 8 | Beats in burst minus one |
| ar_size | output | 3 | Transfer size |
| ar_burst | output | 2 | Burst type, always incrementing |
| ar_prot | output | 3 | Protection value |
| ar_id | output | ID_W | Transaction ID |
| r_valid | input | 1 | Read beat valid |
| r_ready | output | 1 | Block can take a read beat |
| r_data | input | DATA_W | Read beat data |
| r_resp | input | 2 | Read beat response code |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_byte | output | 8 | Extracted byte |
| out_last | output | 1 | Final byte of the request |
| resp_err | output | 1 | One-cycle pulse: response mismatch |

## Verification
The response check and the output stream meet in one cycle. A mismatching beat raises `resp_err` in the same cycle that its first byte is offered on `out_valid`. When that beat is also the request's final beat, the same cycle can also carry `out_last`. The bench provokes this by returning a non-expected code on every beat of requests whose final beat carries one byte, and with random output backpressure. On each cycle it checks that `resp_err` is only ever high alongside `out_valid`. It also checks that the number of high cycles equals the number of beats its own burst arithmetic predicts, and that every byte and `out_last` still match the address-derived pattern.

// File: rtl/axrd_pkg.sv
package axrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_EMIT = 2'd3
    } axrd_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;

    localparam logic [1:0] RSP_OKAY   = 2'd0;
    localparam logic [1:0] RSP_EXOKAY = 2'd1;
    localparam logic [1:0] RSP_SLVERR = 2'd2;
    localparam logic [1:0] RSP_DECERR = 2'd3;

endpackage

// File: rtl/axrd_burst_plan.sv
module axrd_burst_plan #(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int MAX_BEATS = 16,
    parameter int PAGE_W    = 12
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  rem_bytes,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [7:0]        burst_len
);
    localparam int W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 18;

    logic [W-1:0] unit;
    logic [W-1:0] base;
    logic [W-1:0] end_req;
    logic [W-1:0] end_cap;
    logic [W-1:0] end_page;
    logic [W-1:0] end_sel;

    always_comb begin
        unit     = W'(1) << size;
        base     = W'(cur_addr) & ~(unit - W'(1));
        end_req  = W'(cur_addr) + W'(rem_bytes) - W'(1);
        end_cap  = base + (W'(MAX_BEATS) << size) - W'(1);
        end_page = W'(cur_addr) | W'((64'd1 << PAGE_W) - 64'd1);
        end_sel  = end_req;
        if (end_cap < end_sel)  end_sel = end_cap;
        if (end_page < end_sel) end_sel = end_page;
    end

    assign burst_addr = cur_addr & ~((ADDR_W'(1) << size) - ADDR_W'(1));
    assign burst_len  = 8'((end_sel - base) >> size);

endmodule

// File: rtl/axrd_lane_pick.sv
module axrd_lane_pick #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] beat,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        pick
);
    localparam int NLANE = DATA_W / 8;

    logic [7:0] lanes [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lanes[g] = beat[8*g +: 8];
    end

    assign pick = lanes[lane];

endmodule

// File: rtl/axrd_master.sv
module axrd_master
    import axrd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int CNT_W     = 16,
    parameter int MAX_BEATS = 16,
    parameter int PAGE_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [2:0]        req_size,
    input  logic [2:0]        req_prot,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_check,
    input  logic [1:0]        req_expect,
    output logic              req_err,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    output logic [2:0]        ar_prot,
    output logic [ID_W-1:0]   ar_id,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [DATA_W-1:0] r_data,
    input  logic [1:0]        r_resp,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_last,
    output logic              resp_err
);
    localparam int NLANE    = DATA_W / 8;
    localparam int MAX_SIZE = $clog2(NLANE);
    localparam int LANE_W   = (NLANE > 1) ? $clog2(NLANE) : 1;
    localparam int SUM_W    = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;

    typedef struct packed {
        axrd_state_e       state;
        logic [ADDR_W-1:0] cur;
        logic [CNT_W-1:0]  rem;
        logic [8:0]        beats_left;
        logic [2:0]        size;
        logic [2:0]        prot;
        logic [ID_W-1:0]   id;
        logic              chk;
        logic [1:0]        expect_code;
        logic [DATA_W-1:0] beat;
        logic [LANE_W-1:0] lane;
        logic [LANE_W:0]   take;
        logic              req_err;
        logic              resp_err;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] plan_addr;
    logic [7:0]        plan_len;
    logic [LANE_W:0]   size_bytes;
    logic [LANE_W-1:0] off;
    logic [LANE_W:0]   room;
    logic [LANE_W:0]   cnt;
    logic              bad_req;

    axrd_burst_plan #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .MAX_BEATS (MAX_BEATS),
        .PAGE_W    (PAGE_W)
    ) plan_i (
        .cur_addr   (q.cur),
        .rem_bytes  (q.rem),
        .size       (q.size),
        .burst_addr (plan_addr),
        .burst_len  (plan_len)
    );

    axrd_lane_pick #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) pick_i (
        .beat (q.beat),
        .lane (q.lane),
        .pick (out_byte)
    );

    always_comb begin
        d          = q;
        d.req_err  = 1'b0;
        d.resp_err = 1'b0;

        // lane window of the beat that arrives next
        size_bytes = (LANE_W+1)'(1) << q.size;
        off        = q.cur[LANE_W-1:0] & LANE_W'(size_bytes - (LANE_W+1)'(1));
        room       = size_bytes - (LANE_W+1)'(off);
        cnt        = (q.rem < CNT_W'(room)) ? (LANE_W+1)'(q.rem) : room;

        bad_req = (req_bytes == '0) || (req_size > 3'(MAX_SIZE)) ||
                  ((SUM_W'(req_addr) + SUM_W'(req_bytes)) > (SUM_W'(1) << ADDR_W));

        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (bad_req) begin
                        d.req_err = 1'b1;
                    end else begin
                        d.state       = ST_ADDR;
                        d.cur         = req_addr;
                        d.rem         = req_bytes;
                        d.size        = req_size;
                        d.prot        = req_prot;
                        d.id          = req_id;
                        d.chk         = req_check;
                        d.expect_code = req_expect;
                    end
                end
            end
            ST_ADDR: begin
                if (ar_ready) begin
                    d.beats_left = 9'(plan_len) + 9'd1;
                    d.state      = ST_DATA;
                end
            end
            ST_DATA: begin
                if (r_valid) begin
                    d.beat       = r_data;
                    d.lane       = off;
                    d.take       = cnt;
                    d.rem        = q.rem - CNT_W'(cnt);
                    d.cur        = q.cur + ADDR_W'(cnt);
                    d.beats_left = q.beats_left - 9'd1;
                    d.resp_err   = q.chk && (r_resp != q.expect_code);
                    d.state      = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    d.lane = q.lane + LANE_W'(1);
                    d.take = q.take - (LANE_W+1)'(1);
                    if (q.take == (LANE_W+1)'(1)) begin
                        if (q.rem == '0)             d.state = ST_IDLE;
                        else if (q.beats_left == '0) d.state = ST_ADDR;
                        else                         d.state = ST_DATA;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.state == ST_IDLE);
    assign req_err   = q.req_err;
    assign ar_valid  = (q.state == ST_ADDR);
    assign ar_addr   = plan_addr;
    assign ar_len    = plan_len;
    assign ar_size   = q.size;
    assign ar_burst  = BURST_INCR;
    assign ar_prot   = q.prot;
    assign ar_id     = q.id;
    assign r_ready   = (q.state == ST_DATA);
    assign out_valid = (q.state == ST_EMIT);
    assign out_last  = (q.state == ST_EMIT) && (q.rem == '0) &&
                       (q.take == (LANE_W+1)'(1));
    assign resp_err  = q.resp_err;

endmodule

// File: rtl/axrd_master_chk.sv
module axrd_master_chk #(
    parameter int ADDR_W    = 16,
    parameter int MAX_BEATS = 16,
    parameter int PAGE_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic [7:0]        ar_len,
    input logic [2:0]        ar_size,
    input logic              r_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_byte,
    input logic              out_last,
    input logic              req_err
);
    localparam int W = ADDR_W + 20;

    logic [W-1:0] page_off;
    logic [W-1:0] span;

    always_comb begin
        page_off = W'(ar_addr) & W'((64'd1 << PAGE_W) - 64'd1);
        span     = (W'(ar_len) + W'(1)) << ar_size;
    end

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len) && $stable(ar_size)); // R2
    AST_AR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> ((ar_addr & ((ADDR_W'(1) << ar_size) - ADDR_W'(1))) == '0)); // R2
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (32'(ar_len) < MAX_BEATS)); // R3
    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> ((page_off + span) <= (W'(1) << PAGE_W))); // R3
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last)); // R6
    AST_NO_BEAT_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !r_ready); // R6
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !ar_valid && !out_valid); // R9

endmodule

bind axrd_master axrd_master_chk #(
    .ADDR_W    (ADDR_W),
    .MAX_BEATS (MAX_BEATS),
    .PAGE_W    (PAGE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ar_valid  (ar_valid),
    .ar_ready  (ar_ready),
    .ar_addr   (ar_addr),
    .ar_len    (ar_len),
    .ar_size   (ar_size),
    .r_ready   (r_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .req_err   (req_err)
);

// File: tb/axrd_master_tb_top.sv
`timescale 1ns/1ps
module axrd_master_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int ID_W   = 4;
    localparam int CNT_W  = 16;
    localparam int MAXB   = 4;
    localparam int PAGE_W = 12;
    localparam int NL     = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_bytes = '0;
    logic [2:0]        req_size = '0;
    logic [2:0]        req_prot = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic              req_check = 1'b0;
    logic [1:0]        req_expect = '0;
    logic              req_err;
    logic              ar_valid;
    logic              ar_ready = 1'b0;
    logic [ADDR_W-1:0] ar_addr;
    logic [7:0]        ar_len;
    logic [2:0]        ar_size;
    logic [1:0]        ar_burst;
    logic [2:0]        ar_prot;
    logic [ID_W-1:0]   ar_id;
    logic              r_valid = 1'b0;
    logic              r_ready;
    logic [DATA_W-1:0] r_data = '0;
    logic [1:0]        r_resp = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [7:0]        out_byte;
    logic              out_last;
    logic              resp_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    axrd_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
        .CNT_W(CNT_W), .MAX_BEATS(MAXB), .PAGE_W(PAGE_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_size(req_size), .req_prot(req_prot),
        .req_id(req_id), .req_check(req_check), .req_expect(req_expect),
        .req_err(req_err),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
        .ar_prot(ar_prot), .ar_id(ar_id),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_last(out_last), .resp_err(resp_err)
    );

    function automatic logic [7:0] mem_byte(input int a);
        logic [15:0] v;
        v = 16'(a);
        return v[7:0] ^ {v[11:8], v[15:12]} ^ 8'h3C;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic run_req(input int addr, input int n, input int sz, input bit chk,
                           input logic [1:0] expc, input logic [1:0] give, input bit bp);
        int  nbeats;
        int  seen_err;
        bit  got;
        @(negedge clk);
        req_addr = 16'(addr); req_bytes = 16'(n); req_size = 3'(sz);
        req_prot = 3'((addr + sz) % 8); req_id = 4'((n + sz) % 16);
        req_check = chk; req_expect = expc; req_valid = 1'b1;
        do begin got = req_ready; @(negedge clk); end while (!got);
        req_valid = 1'b0;
        check(req_ready == 1'b0 && req_err == 1'b0,
              $sformatf("R1 busy after accept: ready=%0b err=%0b exp 0 0", req_ready, req_err));
        nbeats = 0;
        seen_err = 0;
        fork
            begin : slave
                int cur, rem, s, al, top, beats, off, cnt;
                cur = addr; rem = n; s = 1 << sz;
                while (rem > 0) begin
                    al  = (cur / s) * s;
                    top = imin(cur + rem - 1, al + MAXB * s - 1);
                    top = imin(top, (cur / 4096) * 4096 + 4095);
                    beats = (top - al) / s + 1;
                    while (!ar_valid) @(negedge clk);
                    check(ar_addr == 16'(al) && ar_burst == 2'b01 && ar_size == 3'(sz) &&
                          ar_prot == req_prot && ar_id == req_id,
                          $sformatf("R2 ar addr=%0h burst=%0d size=%0d exp addr=%0h burst=1 size=%0d",
                                    ar_addr, ar_burst, ar_size, al, sz));
                    check(ar_len == 8'(beats - 1),
                          $sformatf("R3 ar_len=%0d exp %0d (addr %0h)", ar_len, beats - 1, al));
                    ar_ready = 1'b1;
                    @(negedge clk);
                    ar_ready = 1'b0;
                    for (int b = 0; b < beats; b++) begin
                        al  = (cur / s) * s;
                        off = cur - al;
                        cnt = imin(rem, s - off);
                        for (int l = 0; l < NL; l++)
                            r_data[8*l +: 8] = (l < s) ? mem_byte(al + l) : 8'hEE;
                        r_resp  = give;
                        r_valid = 1'b1;
                        do begin got = r_ready; @(negedge clk); end while (!got);
                        r_valid = 1'b0;
                        nbeats++;
                        rem -= cnt;
                        cur += cnt;
                    end
                end
            end
            begin : sink
                int cnt_out;
                cnt_out = 0;
                while (cnt_out < n) begin
                    out_ready = bp ? (($urandom % 4) != 0) : 1'b1;
                    if (resp_err) begin
                        seen_err++;
                        check(out_valid == 1'b1,
                              $sformatf("R7 resp_err without byte: out_valid=%0b exp 1", out_valid));
                    end
                    if (out_valid && !out_ready)
                        check(r_ready == 1'b0, $sformatf("R6 r_ready=%0b while stalled exp 0", r_ready));
                    if (out_valid && out_ready) begin
                        check(out_byte == mem_byte(addr + cnt_out),
                              $sformatf("R4 %sbyte %0d of @%0h n=%0d sz=%0d: got %0h exp %0h",
                                        bp ? "R6 " : "", cnt_out, addr, n, sz, out_byte,
                                        mem_byte(addr + cnt_out)));
                        check(out_last == (cnt_out == n - 1),
                              $sformatf("R5 last at byte %0d of %0d: got %0b exp %0b",
                                        cnt_out, n, out_last, cnt_out == n - 1));
                        cnt_out++;
                    end
                    @(negedge clk);
                end
                out_ready = 1'b0;
            end
        join
        if (chk && give != expc)
            check(seen_err == nbeats,
                  $sformatf("R7 mismatch pulses=%0d exp %0d", seen_err, nbeats));
        else
            check(seen_err == 0,
                  $sformatf("R8 mismatch pulses=%0d exp 0 (chk=%0b)", seen_err, chk));
        @(negedge clk);
        check(req_ready == 1'b1 && out_valid == 1'b0 && ar_valid == 1'b0,
              $sformatf("R1 idle after request: ready=%0b out_valid=%0b ar_valid=%0b exp 1 0 0",
                        req_ready, out_valid, ar_valid));
    endtask

    task automatic reject_req(input int addr, input int n, input int sz);
        bit got;
        @(negedge clk);
        req_addr = 16'(addr); req_bytes = 16'(n); req_size = 3'(sz);
        req_check = 1'b1; req_expect = 2'd0; req_valid = 1'b1;
        do begin got = req_ready; @(negedge clk); end while (!got);
        req_valid = 1'b0;
        check(req_err == 1'b1 && req_ready == 1'b1,
              $sformatf("R9 reject @%0h n=%0d sz=%0d: err=%0b ready=%0b exp 1 1",
                        addr, n, sz, req_err, req_ready));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(ar_valid == 1'b0 && req_err == 1'b0 && req_ready == 1'b1,
                  $sformatf("R9 after reject: ar_valid=%0b err=%0b ready=%0b exp 0 0 1",
                            ar_valid, req_err, req_ready));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && ar_valid == 1'b0 && r_ready == 1'b0 && out_valid == 1'b0 &&
              req_err == 1'b0 && resp_err == 1'b0,
              $sformatf("R10 reset: ready=%0b arv=%0b rr=%0b ov=%0b rqe=%0b rse=%0b exp 1 0 0 0 0 0",
                        req_ready, ar_valid, r_ready, out_valid, req_err, resp_err));

        // R2 R3 R4 R5 R6: sweep of size, start offset and length
        for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 8; a++)
                for (int n = 1; n <= 20; n++)
                    run_req(16'h0100 + a, n, sz, 1'b1, 2'd0, 2'd0, bit'(n % 2));

        // R3: page crossings and multi-burst request
        run_req(4090, 12, 2, 1'b1, 2'd0, 2'd0, 1'b1);
        run_req(4093, 40, 0, 1'b1, 2'd0, 2'd0, 1'b0);
        run_req(16'h0301, 100, 2, 1'b0, 2'd0, 2'd0, 1'b1);
        // R9 boundary: ends exactly at top of address space
        run_req(65530, 6, 1, 1'b1, 2'd0, 2'd0, 1'b0);
        // R7: mismatch on every beat, incl. a one-byte final beat
        run_req(16'h0200, 13, 2, 1'b1, 2'd0, 2'd2, 1'b1);
        run_req(16'h0203, 6, 1, 1'b1, 2'd1, 2'd3, 1'b1);
        // R8: check disabled; matching non-OKAY code
        run_req(16'h0200, 9, 2, 1'b0, 2'd0, 2'd3, 1'b1);
        run_req(16'h0207, 9, 1, 1'b1, 2'd1, 2'd1, 1'b0);

        // R9: rejections
        reject_req(65530, 7, 1);
        reject_req(16'h0100, 0, 0);
        reject_req(16'h0100, 4, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule